// File: doc/BRIEF.md
# Random allocation tag generator

This block picks a 4-bit allocation tag for a memory-tagging scheme. A request strobe starts the work. The block steps a 16-bit linear feedback seed four times, and the four feedback bits form a random offset. It then walks upward, modulo 16, from a stored start tag. Any tag whose bit is set in the exclusion mask is passed over, and the tag reached when the offset is used up is the result. The new tag and the advanced seed are kept inside the block, so the next request continues from them.

A load strobe writes a start tag and a seed into the block while it is idle. A random mode with a one-shot entropy input replaces an all-zero seed, because the feedback register would otherwise stay stuck at zero. The walk handles one tag per clock. A one-cycle done pulse marks the moment the result becomes valid.

Top module: `rtg_top`

## Requirements
- R1: After reset, done, tag_out, seed_out and start_out are all zero.
- R2: A request is accepted when the block is idle. The accepting clock edge replaces seed_out with the effective seed after four LFSR steps. Each step shifts the seed right by one and places the XOR of bits 5, 3, 2 and 0 of the old value at bit 15.
- R3: The feedback bit made in step i (i = 0..3) becomes bit i of the 4-bit offset.
- R4: If the sampled exclusion mask is 16'hFFFF, the result is tag 0 and done rises on the accepting edge.
- R5: With offset 0, the result is the start tag when its mask bit is clear. Otherwise the walk goes upward, wrapping mod 16, to the first tag whose mask bit is clear.
- R6: With a nonzero offset N, the walk increments the tag mod 16 and counts each tag whose mask bit is clear. The result is the tag reached on the N-th count.
- R7: The exclusion mask is req_mask OR cfg_mask, sampled on the accepting edge. Changes to either input after that edge do not affect the result.
- R8: When rand_mode is 1 and the seed is zero, the effective seed is rnd_seed if rnd_ok is 1 and rnd_seed is nonzero, and 1 otherwise. A nonzero seed, or rand_mode at 0, leaves the seed unchanged.
- R9: On the edge that raises done, start_out takes the result tag, and tag_out holds that tag until the next result.
- R10: When idle, ld_en writes ld_start and ld_seed into the block. If req is high in the same cycle, the request uses the loaded values. While a walk is in progress, req and ld_en are ignored.
- R11: done is a one-cycle pulse, and the walk visits at most one tag per clock. Counting the accepting edge as edge 1, done is visible after edge 1 for an all-ones mask, after edge k+2 for offset 0 with k skipped tags, and after edge n+1 for a nonzero offset that takes n increments.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe |
| req_mask | input | 16 | Per-request exclusion mask |
| cfg_mask | input | 16 | Configured exclusion mask |
| rand_mode | input | 1 | Enables substitution of a zero seed |
| rnd_ok | input | 1 | The entropy source produced a value |
| rnd_seed | input | 16 | One-shot entropy value |
| ld_en | input | 1 | Load strobe for start tag and seed |
| ld_start | input | 4 | Start tag to load |
| ld_seed | input | 16 | Seed to load |
| done | output | 1 | Result valid pulse |
| tag_out | output | 4 | Result tag |
| seed_out | output | 16 | Stored seed |
| start_out | output | 4 | Stored start tag |

## Verification
Two functions can fall in the same cycle: a load and a request. Both are tested together, and the result must show that the request used the freshly loaded start tag and seed. A second kind of overlap happens when req and ld_en are raised during a long walk. The block must ignore them, and this is judged at the ports: the seed stays the same every cycle, done arrives at the predicted cycle, and start_out afterwards equals the result tag and not the values that were offered. The reference model in the bench is compared against the block on every clock.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } rtg_state_e;
endpackage

// File: rtl/rtg_seed_sel.sv
module rtg_seed_sel #(
  parameter int SEED_W = 16
) (
  input  logic [SEED_W-1:0] seed_i,
  input  logic              rand_mode_i,
  input  logic              rnd_ok_i,
  input  logic [SEED_W-1:0] rnd_seed_i,
  output logic [SEED_W-1:0] seed_o
);
  logic use_rnd;
  logic [SEED_W-1:0] subst;

  always_comb begin
    use_rnd = rnd_ok_i && (rnd_seed_i != '0);
    subst   = use_rnd ? rnd_seed_i : SEED_W'(1);
    seed_o  = (rand_mode_i && (seed_i == '0)) ? subst : seed_i;
  end
endmodule

// File: rtl/rtg_lfsr.sv
module rtg_lfsr #(
  parameter int              SEED_W   = 16,
  parameter int              STEPS    = 4,
  parameter logic [SEED_W-1:0] TAP_MASK = 16'h002D
) (
  input  logic [SEED_W-1:0] seed_i,
  output logic [SEED_W-1:0] seed_o,
  output logic [STEPS-1:0]  bits_o
);
  logic [SEED_W-1:0] chain [0:STEPS];

  assign chain[0] = seed_i;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    logic fb;
    assign fb           = ^(chain[g] & TAP_MASK);
    assign chain[g+1]   = {fb, chain[g][SEED_W-1:1]};
    assign bits_o[g]    = fb;
  end

  assign seed_o = chain[STEPS];
endmodule

// File: rtl/rtg_walker.sv
module rtg_walker
  import rtg_pkg::*;
#(
  parameter int TAG_W = 4,
  localparam int NT   = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [TAG_W-1:0] go_start_i,
  input  logic [TAG_W-1:0] go_off_i,
  input  logic [NT-1:0]    go_mask_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic [TAG_W-1:0] fin_tag_o,
  output logic [NT-1:0]    mask_o
);
  localparam int CW = 2 * TAG_W;

  rtg_state_e       state_q, state_d;
  logic [TAG_W-1:0] cur_q, cur_d;
  logic [TAG_W-1:0] rem_q, rem_d;
  logic [TAG_W-1:0] nxt;
  logic             zm_q, zm_d;
  logic [NT-1:0]    mask_q, mask_d;
  logic [CW-1:0]    steps_q, steps_d;

  // next state
  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    rem_d     = rem_q;
    zm_d      = zm_q;
    mask_d    = mask_q;
    steps_d   = steps_q;
    fin_o     = 1'b0;
    fin_tag_o = '0;
    nxt       = cur_q + 1'b1;
    case (state_q)
      ST_IDLE: begin
        if (go_i) begin
          mask_d  = go_mask_i;
          steps_d = '0;
          if (&go_mask_i) begin
            fin_o = 1'b1;
          end else begin
            state_d = ST_WALK;
            cur_d   = go_start_i;
            rem_d   = go_off_i;
            zm_d    = (go_off_i == '0);
          end
        end
      end
      ST_WALK: begin
        steps_d = steps_q + 1'b1;
        if (zm_q) begin
          if (!mask_q[cur_q]) begin
            fin_o     = 1'b1;
            fin_tag_o = cur_q;
            state_d   = ST_IDLE;
          end else begin
            cur_d = nxt;
          end
        end else begin
          cur_d = nxt;
          if (!mask_q[nxt]) begin
            if (rem_q == TAG_W'(1)) begin
              fin_o     = 1'b1;
              fin_tag_o = nxt;
              state_d   = ST_IDLE;
            end else begin
              rem_d = rem_q - 1'b1;
            end
          end
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      rem_q   <= '0;
      zm_q    <= 1'b0;
      mask_q  <= '0;
      steps_q <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      rem_q   <= rem_d;
      zm_q    <= zm_d;
      mask_q  <= mask_d;
      steps_q <= steps_d;
    end
  end

  assign busy_o = (state_q == ST_WALK);
  assign mask_o = mask_q;

  // R6: a walk with a nonzero offset always has a count left
  p_rem_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !zm_q) |-> (rem_q != '0));

  // R11: the walk length stays below 16*15 tag visits
  p_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (steps_q < CW'(NT * (NT - 1))));

  // R11: the walk moves by exactly one tag per clock
  p_one_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !fin_o) |=> (cur_q == $past(cur_q) + 1'b1) || (zm_q && $stable(cur_q)));
endmodule

// File: rtl/rtg_top.sv
module rtg_top #(
  parameter int                TAG_W    = 4,
  parameter int                SEED_W   = 16,
  parameter logic [SEED_W-1:0] TAP_MASK = 16'h002D,
  localparam int               NT       = 1 << TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [NT-1:0]     req_mask,
  input  logic [NT-1:0]     cfg_mask,
  input  logic              rand_mode,
  input  logic              rnd_ok,
  input  logic [SEED_W-1:0] rnd_seed,
  input  logic              ld_en,
  input  logic [TAG_W-1:0]  ld_start,
  input  logic [SEED_W-1:0] ld_seed,
  output logic              done,
  output logic [TAG_W-1:0]  tag_out,
  output logic [SEED_W-1:0] seed_out,
  output logic [TAG_W-1:0]  start_out
);
  logic              busy, fin, accept, ld_take;
  logic [TAG_W-1:0]  fin_tag, start_src, offset;
  logic [SEED_W-1:0] seed_src, seed_eff, seed_adv;
  logic [NT-1:0]     mask_w;

  logic              done_q;
  logic [TAG_W-1:0]  tag_q, tag_d, start_q, start_d;
  logic [SEED_W-1:0] seed_q, seed_d;
  logic              seed_en, start_en;

  always_comb begin
    accept    = req && !busy;
    ld_take   = ld_en && !busy;
    start_src = ld_take ? ld_start : start_q;
    seed_src  = ld_take ? ld_seed  : seed_q;
  end

  rtg_seed_sel #(.SEED_W(SEED_W)) u_sel (
    .seed_i      (seed_src),
    .rand_mode_i (rand_mode),
    .rnd_ok_i    (rnd_ok),
    .rnd_seed_i  (rnd_seed),
    .seed_o      (seed_eff)
  );

  rtg_lfsr #(.SEED_W(SEED_W), .STEPS(TAG_W), .TAP_MASK(TAP_MASK)) u_lfsr (
    .seed_i (seed_eff),
    .seed_o (seed_adv),
    .bits_o (offset)
  );

  rtg_walker #(.TAG_W(TAG_W)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (accept),
    .go_start_i (start_src),
    .go_off_i   (offset),
    .go_mask_i  (req_mask | cfg_mask),
    .busy_o     (busy),
    .fin_o      (fin),
    .fin_tag_o  (fin_tag),
    .mask_o     (mask_w)
  );

  // next state with explicit enables
  always_comb begin
    seed_en  = accept || ld_take;
    seed_d   = accept ? seed_adv : ld_seed;
    start_en = fin || ld_take;
    start_d  = fin ? fin_tag : ld_start;
    tag_d    = fin_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      tag_q   <= '0;
      seed_q  <= '0;
      start_q <= '0;
    end else begin
      done_q <= fin;
      if (fin)      tag_q   <= tag_d;
      if (seed_en)  seed_q  <= seed_d;
      if (start_en) start_q <= start_d;
    end
  end

  assign done      = done_q;
  assign tag_out   = tag_q;
  assign seed_out  = seed_q;
  assign start_out = start_q;

  // R9: the stored start tag follows the result on the done edge
  p_start_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (start_out == tag_out));

  // R4: a fully excluded mask gives tag zero
  p_all_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (&mask_w)) |-> (tag_out == '0));

  // R5: a result is never an excluded tag
  p_not_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(&mask_w)) |-> !mask_w[tag_out]);

  // R10: nothing alters the seed while a walk is running
  p_seed_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(seed_out));

  // R8: random mode never leaves a zero seed behind
  p_seed_nz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rand_mode) |=> (seed_out != '0));
endmodule

// File: tb/rtg_top_test.sv
module rtg_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] req_mask = '0;
  logic [15:0] cfg_mask = '0;
  logic        rand_mode = 1'b0;
  logic        rnd_ok = 1'b0;
  logic [15:0] rnd_seed = '0;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_start = '0;
  logic [15:0] ld_seed = '0;
  logic        done;
  logic [3:0]  tag_out;
  logic [15:0] seed_out;
  logic [3:0]  start_out;

  int          n_vec = 0;
  int          n_bad = 0;
  bit          ended = 1'b0;
  logic [15:0] m_seed = '0;
  logic [3:0]  m_start = '0;

  rtg_top uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_mask(req_mask),
    .cfg_mask(cfg_mask), .rand_mode(rand_mode), .rnd_ok(rnd_ok),
    .rnd_seed(rnd_seed), .ld_en(ld_en), .ld_start(ld_start),
    .ld_seed(ld_seed), .done(done), .tag_out(tag_out),
    .seed_out(seed_out), .start_out(start_out)
  );

  always #4 clk = ~clk;

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    summary();
  end

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // one request; the model is kept in m_seed/m_start
  task automatic run_req(input logic [15:0] rm, input logic [15:0] cm,
                         input logic rmode, input logic ok,
                         input logic [15:0] rs, input logic ld,
                         input logic [3:0] lst, input logic [15:0] lsd,
                         input logic poke, input string rq);
    logic [15:0] msk, es;
    logic [3:0]  off, t;
    logic        fb;
    int          lat, k, cnt;
    @(negedge clk);
    req = 1'b1; req_mask = rm; cfg_mask = cm; rand_mode = rmode;
    rnd_ok = ok; rnd_seed = rs; ld_en = ld; ld_start = lst; ld_seed = lsd;
    if (ld) begin m_seed = lsd; m_start = lst; end
    es = m_seed;
    if (rmode && es == 16'h0) es = (ok && rs != 16'h0) ? rs : 16'h0001;
    for (int i = 0; i < 4; i++) begin
      fb = es[5] ^ es[3] ^ es[2] ^ es[0];
      es = {fb, es[15:1]};
      off[i] = fb;
    end
    msk = rm | cm;
    t = m_start;
    k = 0;
    if (msk == 16'hFFFF) begin
      t = 4'd0; lat = 1;
    end else if (off == 4'd0) begin
      while (msk[t]) begin t = t + 4'd1; k++; end
      lat = k + 2;
    end else begin
      cnt = int'(off);
      while (cnt > 0) begin
        t = t + 4'd1; k++;
        if (!msk[t]) cnt--;
      end
      lat = k + 1;
    end
    m_seed = es;
    for (int c = 1; c <= lat; c++) begin
      @(negedge clk);
      chk("R2", "seed_out", 32'(seed_out), 32'(m_seed));
      chk("R11", "done", 32'(done), 32'(c == lat));
      if (c == lat) begin
        chk(rq, "tag_out", 32'(tag_out), 32'(t));
        chk("R9", "start_out", 32'(start_out), 32'(t));
      end
      if (c == 1) begin
        req = 1'b0; ld_en = 1'b0;
        req_mask = 16'h0; cfg_mask = 16'h0;   // R7: late changes ignored
        rand_mode = 1'b0;
        if (poke && lat > 2) begin            // R10: offered while busy
          req = 1'b1; ld_en = 1'b1;
          ld_seed = 16'h5555; ld_start = t ^ 4'h9;
        end
      end else begin
        req = 1'b0; ld_en = 1'b0;
      end
    end
    m_start = t;
    @(negedge clk);
    chk("R11", "done after pulse", 32'(done), 32'h0);
    chk(rq, "tag_out held", 32'(tag_out), 32'(t));
    chk("R10", "seed_out kept", 32'(seed_out), 32'(m_seed));
    chk("R10", "start_out kept", 32'(start_out), 32'(t));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "done", 32'(done), 32'h0);
    chk("R1", "tag_out", 32'(tag_out), 32'h0);
    chk("R1", "seed_out", 32'(seed_out), 32'h0);
    chk("R1", "start_out", 32'(start_out), 32'h0);
    rst_n = 1'b1;
    // R10: load and request in the same cycle
    run_req(16'h0000, 16'h0000, 0, 0, 16'h0, 1, 4'd3, 16'hACE1, 0, "R10");
    // R3 / R6: chained requests with partial masks
    run_req(16'h00F0, 16'h0000, 0, 0, 16'h0, 0, 4'd0, 16'h0, 0, "R3");
    run_req(16'h0F0F, 16'h3000, 0, 0, 16'h0, 0, 4'd0, 16'h0, 0, "R7");
    run_req(16'h8421, 16'h0000, 0, 0, 16'h0, 0, 4'd0, 16'h0, 0, "R6");
    // R4: full exclusion from either source
    run_req(16'hFFFF, 16'h0000, 0, 0, 16'h0, 0, 4'd0, 16'h0, 0, "R4");
    run_req(16'h00FF, 16'hFF00, 0, 0, 16'h0, 0, 4'd0, 16'h0, 0, "R4");
    // R5: zero seed gives offset 0; wrap past 14,15,0
    run_req(16'hC001, 16'h0000, 0, 0, 16'h0, 1, 4'd14, 16'h0000, 0, "R5");
    run_req(16'h0000, 16'h0000, 0, 0, 16'h0, 1, 4'd7, 16'h0000, 0, "R5");
    // R8: substitution of a zero seed
    run_req(16'h0000, 16'h0000, 1, 1, 16'h1234, 0, 4'd0, 16'h0, 0, "R8");
    run_req(16'h0000, 16'h0000, 1, 0, 16'h9999, 1, 4'd2, 16'h0000, 0, "R8");
    run_req(16'h0000, 16'h0000, 1, 1, 16'h0000, 1, 4'd9, 16'h0000, 0, "R8");
    run_req(16'h0000, 16'h0000, 1, 1, 16'h7777, 1, 4'd4, 16'hBEEF, 0, "R8");
    // R6: single allowed tag forces long walks; R10 poke while busy
    run_req(16'hFFDF, 16'h0000, 0, 0, 16'h0, 1, 4'd6, 16'hACE1, 1, "R6");
    run_req(16'h0000, 16'hFFDF, 0, 0, 16'h0, 0, 4'd0, 16'h0, 1, "R10");
    for (int j = 0; j < 6; j++)
      run_req(16'h1248 << j, 16'h0101, 0, 0, 16'h0, 0, 4'd0, 16'h0, j[0], "R6");
    summary();
  end
endmodule